// File: doc/BRIEF.md
# Chip-Select Gated Command/Address Register with Duplicated Outputs

This block sits between a memory controller and a bank of memory devices on a module. Each rising clock edge it registers a wide data word, the active-low chip selects, the clock-enable bits and the termination-control bits. Every registered bit drives two copies, an A output and a B output, so that two groups of devices can be driven from separate loads with equal values.

A static gating input sets how the data word is treated. With gating off, the data word is captured on every edge. With gating on, the data word updates only on edges where at least one chip select is asserted (low), and keeps its last value when all chip selects are high. The chip selects, clock enables and termination bits are never gated.

An active-low reset clears every register and drives every output low without waiting for a clock edge. Its release is brought into the clock domain through a short synchroniser, so the first capture falls on a clean edge some cycles after the reset input rises.

Top module: `cs_gated_fanout_reg`

## Requirements
- R1: With `gate_en` = 1 and every bit of `cs_n_in` equal to 1 at a rising edge, `dat_qa`/`dat_qb` keep their previous value after that edge.
- R2: With `gate_en` = 1 and at least one bit of `cs_n_in` equal to 0 at a rising edge, `dat_qa`/`dat_qb` take the value of `dat_in` sampled at that edge.
- R3: With `gate_en` = 0, `dat_qa`/`dat_qb` take `dat_in` at every rising edge for all chip-select patterns (00, 01, 10, 11).
- R4: `cke_qa`/`cke_qb` and `odt_qa`/`odt_qb` take `cke_in` and `odt_in` at every rising edge, whatever `gate_en` and `cs_n_in` are.
- R5: `cs_n_qa`/`cs_n_qb` take `cs_n_in` at every rising edge, whatever `gate_en` is.
- R6: `rst_n` = 0 forces every output to 0 at once, without a clock edge, and overrides the gating (outputs are 0 even if gating would hold them).
- R7: Each A output equals its B output at all times.
- R8: Outputs come straight from flip-flops: a change of any input between edges leaves the outputs unchanged until the next rising edge.
- R9: After `rst_n` rises, the registers stay cleared for `RST_SYNC_STAGES` rising edges (default 2) and capture first on edge `RST_SYNC_STAGES`+1; outputs stay 0 meanwhile and stay 0 afterwards while inputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| gate_en | input | 1 | 1: data word updates only when a chip select is low; 0: updates every edge |
| cs_n_in | input | CS_W | Active-low chip selects |
| dat_in | input | DATA_W | Command/address data word |
| cke_in | input | CKE_W | Clock-enable bits |
| odt_in | input | ODT_W | Termination-control bits |
| dat_qa | output | DATA_W | Registered data word, copy A |
| dat_qb | output | DATA_W | Registered data word, copy B |
| cs_n_qa | output | CS_W | Registered chip selects, copy A |
| cs_n_qb | output | CS_W | Registered chip selects, copy B |
| cke_qa | output | CKE_W | Registered clock enables, copy A |
| cke_qb | output | CKE_W | Registered clock enables, copy B |
| odt_qa | output | ODT_W | Registered termination bits, copy A |
| odt_qb | output | ODT_W | Registered termination bits, copy B |

## Verification
The capture properties assume `gate_en` is a static program setting and that inputs are stable around each rising edge; the stimulus changes every input only on the falling edge, half a period away from capture, and changes `gate_en` only between whole vectors. The capture checks are disabled while the synchronised reset is low, on the assumption that the reset input is held long enough for the synchroniser to clear; the bench holds it low for several edges and asserts it mid-cycle to exercise the asynchronous clear apart from any edge.

// File: rtl/cs_fanout_pkg.sv
package cs_fanout_pkg;

   // How each A/B output pair is built.
   typedef enum logic [0:0] {
      COPY_SHARED   = 1'b0,  // one flop drives both copies
      COPY_SEPARATE = 1'b1   // one flop per copy
   } copy_mode_e;

   localparam int unsigned DEF_DATA_W = 22;
   localparam int unsigned DEF_CS_W   = 2;
   localparam int unsigned DEF_CKE_W  = 2;
   localparam int unsigned DEF_ODT_W  = 2;
   localparam int unsigned DEF_SYNC   = 2;

endpackage

// File: rtl/rst_release_sync.sv
module rst_release_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   output logic rst_n_sync
);
   if (STAGES < 1) begin : g_bad_stages
      $error("rst_release_sync: STAGES must be at least 1");
   end

   logic [STAGES-1:0] chain_q;

   if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain_q <= 1'b0;
         else        chain_q <= 1'b1;
      end
   end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain_q <= '0;
         else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
      end
   end

   assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/cs_gate_decode.sv
module cs_gate_decode #(
   parameter int unsigned CS_W = 2
) (
   input  logic            gate_en,
   input  logic [CS_W-1:0] cs_n,
   output logic            capture_en
);
   if (CS_W < 1) begin : g_bad_cs
      $error("cs_gate_decode: CS_W must be at least 1");
   end

   logic all_deselected;

   always_comb begin
      all_deselected = &cs_n;
      capture_en     = !(gate_en && all_deselected);
   end
endmodule

// File: rtl/dup_reg_bank.sv
module dup_reg_bank
   import cs_fanout_pkg::*;
#(
   parameter int unsigned W         = 1,
   parameter copy_mode_e  COPY_MODE = COPY_SEPARATE
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         en,
   input  logic [W-1:0] d,
   output logic [W-1:0] q_a,
   output logic [W-1:0] q_b
);
   if (W < 1) begin : g_bad_w
      $error("dup_reg_bank: W must be at least 1");
   end

   if (COPY_MODE == COPY_SEPARATE) begin : g_separate
      logic [W-1:0] a_q, b_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)  a_q <= '0;
         else if (en) a_q <= d;
      end
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)  b_q <= '0;
         else if (en) b_q <= d;
      end
      assign q_a = a_q;
      assign q_b = b_q;
   end else begin : g_shared
      logic [W-1:0] s_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)  s_q <= '0;
         else if (en) s_q <= d;
      end
      assign q_a = s_q;
      assign q_b = s_q;
   end
endmodule

// File: rtl/cs_gated_fanout_reg.sv
module cs_gated_fanout_reg
   import cs_fanout_pkg::*;
#(
   parameter int unsigned DATA_W          = DEF_DATA_W,
   parameter int unsigned CS_W            = DEF_CS_W,
   parameter int unsigned CKE_W           = DEF_CKE_W,
   parameter int unsigned ODT_W           = DEF_ODT_W,
   parameter int unsigned RST_SYNC_STAGES = DEF_SYNC,
   parameter copy_mode_e  COPY_MODE       = COPY_SEPARATE
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              gate_en,
   input  logic [CS_W-1:0]   cs_n_in,
   input  logic [DATA_W-1:0] dat_in,
   input  logic [CKE_W-1:0]  cke_in,
   input  logic [ODT_W-1:0]  odt_in,
   output logic [DATA_W-1:0] dat_qa,
   output logic [DATA_W-1:0] dat_qb,
   output logic [CS_W-1:0]   cs_n_qa,
   output logic [CS_W-1:0]   cs_n_qb,
   output logic [CKE_W-1:0]  cke_qa,
   output logic [CKE_W-1:0]  cke_qb,
   output logic [ODT_W-1:0]  odt_qa,
   output logic [ODT_W-1:0]  odt_qb
);
   // Sideband (never gated) bits are banked together.
   localparam int unsigned SIDE_W = CS_W + CKE_W + ODT_W;

   if (DATA_W < 1 || CKE_W < 1 || ODT_W < 1) begin : g_bad_width
      $error("cs_gated_fanout_reg: all widths must be at least 1");
   end
   if (RST_SYNC_STAGES < 1) begin : g_bad_sync
      $error("cs_gated_fanout_reg: RST_SYNC_STAGES must be at least 1");
   end

   logic              rst_int_n;
   logic              dat_capture;
   logic [SIDE_W-1:0] side_d, side_qa, side_qb;

   rst_release_sync #(
      .STAGES (RST_SYNC_STAGES)
   ) u_rst_sync (
      .clk        (clk),
      .rst_n      (rst_n),
      .rst_n_sync (rst_int_n)
   );

   cs_gate_decode #(
      .CS_W (CS_W)
   ) u_gate (
      .gate_en    (gate_en),
      .cs_n       (cs_n_in),
      .capture_en (dat_capture)
   );

   dup_reg_bank #(
      .W         (DATA_W),
      .COPY_MODE (COPY_MODE)
   ) u_dat_bank (
      .clk   (clk),
      .rst_n (rst_int_n),
      .en    (dat_capture),
      .d     (dat_in),
      .q_a   (dat_qa),
      .q_b   (dat_qb)
   );

   assign side_d = {odt_in, cke_in, cs_n_in};

   dup_reg_bank #(
      .W         (SIDE_W),
      .COPY_MODE (COPY_MODE)
   ) u_side_bank (
      .clk   (clk),
      .rst_n (rst_int_n),
      .en    (1'b1),
      .d     (side_d),
      .q_a   (side_qa),
      .q_b   (side_qb)
   );

   assign cs_n_qa = side_qa[CS_W-1:0];
   assign cs_n_qb = side_qb[CS_W-1:0];
   assign cke_qa  = side_qa[CS_W +: CKE_W];
   assign cke_qb  = side_qb[CS_W +: CKE_W];
   assign odt_qa  = side_qa[CS_W+CKE_W +: ODT_W];
   assign odt_qb  = side_qb[CS_W+CKE_W +: ODT_W];
endmodule

// File: rtl/cs_fanout_chk.sv
module cs_fanout_chk #(
   parameter int unsigned DATA_W = 22,
   parameter int unsigned CS_W   = 2,
   parameter int unsigned CKE_W  = 2,
   parameter int unsigned ODT_W  = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              rst_int_n,
   input logic              gate_en,
   input logic [CS_W-1:0]   cs_n_in,
   input logic [DATA_W-1:0] dat_in,
   input logic [CKE_W-1:0]  cke_in,
   input logic [ODT_W-1:0]  odt_in,
   input logic [DATA_W-1:0] dat_qa,
   input logic [DATA_W-1:0] dat_qb,
   input logic [CS_W-1:0]   cs_n_qa,
   input logic [CS_W-1:0]   cs_n_qb,
   input logic [CKE_W-1:0]  cke_qa,
   input logic [CKE_W-1:0]  cke_qb,
   input logic [ODT_W-1:0]  odt_qa,
   input logic [ODT_W-1:0]  odt_qb
);
   AST_HOLD_DESELECTED: assert property (@(posedge clk) disable iff (!rst_int_n)
      (gate_en && (&cs_n_in)) |=> $stable(dat_qa)); // R1
   AST_CAPTURE_SELECTED: assert property (@(posedge clk) disable iff (!rst_int_n)
      (gate_en && !(&cs_n_in)) |=> (dat_qa == $past(dat_in))); // R2
   AST_CAPTURE_UNGATED: assert property (@(posedge clk) disable iff (!rst_int_n)
      !gate_en |=> (dat_qa == $past(dat_in))); // R3
   AST_SIDEBAND_CAPTURE: assert property (@(posedge clk) disable iff (!rst_int_n)
      rst_int_n |=> (cke_qa == $past(cke_in)) && (odt_qa == $past(odt_in))); // R4
   AST_CS_CAPTURE: assert property (@(posedge clk) disable iff (!rst_int_n)
      rst_int_n |=> (cs_n_qa == $past(cs_n_in))); // R5
   AST_RESET_CLEARS: assert property (@(posedge clk)
      !rst_n |-> (dat_qa == '0) && (cs_n_qa == '0) && (cke_qa == '0) && (odt_qa == '0)); // R6
   AST_COPIES_EQUAL: assert property (@(posedge clk)
      (dat_qa == dat_qb) && (cs_n_qa == cs_n_qb) && (cke_qa == cke_qb) && (odt_qa == odt_qb)); // R7
   AST_RELEASE_QUIET: assert property (@(posedge clk)
      !rst_int_n |-> (dat_qb == '0) && (cs_n_qb == '0) && (cke_qb == '0) && (odt_qb == '0)); // R9
endmodule

bind cs_gated_fanout_reg cs_fanout_chk #(
   .DATA_W (DATA_W),
   .CS_W   (CS_W),
   .CKE_W  (CKE_W),
   .ODT_W  (ODT_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .rst_int_n (rst_int_n),
   .gate_en   (gate_en),
   .cs_n_in   (cs_n_in),
   .dat_in    (dat_in),
   .cke_in    (cke_in),
   .odt_in    (odt_in),
   .dat_qa    (dat_qa),
   .dat_qb    (dat_qb),
   .cs_n_qa   (cs_n_qa),
   .cs_n_qb   (cs_n_qb),
   .cke_qa    (cke_qa),
   .cke_qb    (cke_qb),
   .odt_qa    (odt_qa),
   .odt_qb    (odt_qb)
);

// File: tb/test_cs_gated_fanout_reg.sv
`timescale 1ns/100ps
module test_cs_gated_fanout_reg;
   localparam int DW = 22;
   localparam int NV = 10;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          gate_en = 1'b0;
   logic [1:0]    cs_n_in = 2'b00;
   logic [DW-1:0] dat_in = '0;
   logic [1:0]    cke_in = 2'b00;
   logic [1:0]    odt_in = 2'b00;
   logic [DW-1:0] dat_qa, dat_qb;
   logic [1:0]    cs_n_qa, cs_n_qb, cke_qa, cke_qb, odt_qa, odt_qb;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   always #2.5 clk = ~clk;

   cs_gated_fanout_reg i_cs_gated_fanout_reg (
      .clk (clk), .rst_n (rst_n), .gate_en (gate_en), .cs_n_in (cs_n_in),
      .dat_in (dat_in), .cke_in (cke_in), .odt_in (odt_in),
      .dat_qa (dat_qa), .dat_qb (dat_qb), .cs_n_qa (cs_n_qa), .cs_n_qb (cs_n_qb),
      .cke_qa (cke_qa), .cke_qb (cke_qb), .odt_qa (odt_qa), .odt_qb (odt_qb)
   );

   // Vector table: {gate_en, cs_n}, data in, expected data out after the edge.
   localparam logic [2:0] V_CTL [NV] = '{
      3'b0_00, 3'b0_11, 3'b0_01, 3'b0_10, 3'b1_11,
      3'b1_01, 3'b1_11, 3'b1_10, 3'b1_00, 3'b1_11 };
   localparam logic [DW-1:0] V_DAT [NV] = '{
      22'h2AAAAA, 22'h155555, 22'h3FFFFF, 22'h000001, 22'h3C3C3C,
      22'h123456, 22'h3FFFFF, 22'h0ABCDE, 22'h200000, 22'h000000 };
   localparam logic [DW-1:0] V_EXP [NV] = '{
      22'h2AAAAA, 22'h155555, 22'h3FFFFF, 22'h000001, 22'h000001,
      22'h123456, 22'h123456, 22'h0ABCDE, 22'h200000, 22'h200000 };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic chk_all_zero(input string req);
      chk(req, {10'd0, dat_qa}, 32'd0);
      chk(req, {10'd0, dat_qb}, 32'd0);
      chk(req, {24'd0, cs_n_qa, cke_qa, odt_qa, cs_n_qb}, 32'd0);
      chk(req, {28'd0, cke_qb, odt_qb}, 32'd0);
   endtask

   initial begin
      // R6: reset state
      repeat (3) @(posedge clk);
      #1 chk_all_zero("R6 reset state");
      @(negedge clk) rst_n = 1'b1;
      repeat (4) @(posedge clk);
      #1 chk_all_zero("R9 quiet after release");

      // R1 R2 R3 R4 R5 R7: table walk
      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         gate_en = V_CTL[i][2];
         cs_n_in = V_CTL[i][1:0];
         dat_in  = V_DAT[i];
         cke_in  = 2'(i);
         odt_in  = ~2'(i);
         @(posedge clk);
         #1;
         if (!V_CTL[i][2])            chk("R3 ungated capture", {10'd0, dat_qa}, {10'd0, V_EXP[i]});
         else if (&V_CTL[i][1:0])     chk("R1 deselected hold", {10'd0, dat_qa}, {10'd0, V_EXP[i]});
         else                         chk("R2 selected capture", {10'd0, dat_qa}, {10'd0, V_EXP[i]});
         chk("R7 data copies", {10'd0, dat_qb}, {10'd0, V_EXP[i]});
         chk("R5 cs capture", {30'd0, cs_n_qa}, {30'd0, V_CTL[i][1:0]});
         chk("R4 cke capture", {30'd0, cke_qa}, {30'd0, 2'(i)});
         chk("R4 odt capture", {30'd0, odt_qa}, {30'd0, ~2'(i)});
         chk("R7 side copies", {26'd0, cs_n_qb, cke_qb, odt_qb}, {26'd0, cs_n_qa, cke_qa, odt_qa});
      end

      // R8: mid-cycle input change does not reach the outputs
      @(negedge clk);
      gate_en = 1'b0; cs_n_in = 2'b01; dat_in = 22'h0F0F0F; cke_in = 2'b11; odt_in = 2'b11;
      #1 chk("R8 no pass-through", {10'd0, dat_qa}, {10'd0, 22'h200000});
      chk("R8 no pass-through side", {30'd0, cke_qa}, {30'd0, 2'(NV-1)});
      @(posedge clk);
      #1 chk("R8 update at edge", {10'd0, dat_qa}, {10'd0, 22'h0F0F0F});

      // R6: async clear mid-cycle, overriding a gated hold
      @(negedge clk);
      gate_en = 1'b1; cs_n_in = 2'b11;
      @(posedge clk);
      #1 rst_n = 1'b0;
      #0.5 chk_all_zero("R6 async clear over hold");

      // R9: release with all inputs high, first capture on third edge
      @(negedge clk);
      gate_en = 1'b1; cs_n_in = 2'b00; dat_in = '1; cke_in = 2'b11; odt_in = 2'b11;
      rst_n = 1'b1;
      @(posedge clk);
      #1 chk("R9 edge 1 cleared", {10'd0, dat_qa}, 32'd0);
      @(posedge clk);
      #1 chk("R9 edge 2 cleared", {10'd0, dat_qa}, 32'd0);
      chk("R9 edge 2 side cleared", {30'd0, cke_qa}, 32'd0);
      @(posedge clk);
      #1 chk("R9 edge 3 capture", {10'd0, dat_qa}, {10'd0, 22'h3FFFFF});
      chk("R9 edge 3 side capture", {30'd0, cke_qa}, {30'd0, 2'b11});

      done = 1'b1;
   end

   initial begin
      fork
         begin
            wait (done);
         end
         begin
            repeat (20000) @(posedge clk);
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
         end
      join_any
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule